// File: doc/BRIEF.md
# Dual-Lane Register Renamer

This block renames a group of two instructions every cycle. Each lane presents two architectural source indices and an optional destination index. The block returns physical source tags. For a lane that writes a register, it also returns a freshly allocated physical destination tag and the physical register that the destination was mapped to before. The commit logic later releases that previous mapping through the free port.

The block owns the architectural-to-physical map table and a circular queue of free physical registers. The two lanes of a group may depend on each other: lane 1 may read or overwrite what lane 0 writes. Those cases are found by comparing lane indices alongside the table read, and lane 0's new tag is substituted where it applies. Architectural register 0 is hard-wired and is never renamed. If the free queue cannot cover every destination in the group, the whole group is held back and no state moves.

Top module: `dual_rename`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The free queue holds physical registers ARCH_REGS through PHYS_REGS-1 in ascending order, so the first tag handed out is ARCH_REGS.
- R2: A lane allocates when it is valid, has its write flag set and names a destination other than 0. Allocated tags come from the queue head, lane 0 before lane 1. Two tags handed out together are distinct and never 0.
- R3: Each source tag equals the current table entry for that architectural index, where no same-group write applies.
- R4: When lane 0 allocates and a lane 1 source names lane 0's destination, that lane 1 source tag is lane 0's new tag.
- R5: For an allocating lane, the previous-mapping output is the table entry of its destination. For lane 1 it is lane 0's new tag when both lanes name the same destination.
- R6: When both lanes allocate the same destination, later reads of that destination return lane 1's tag.
- R7: Index 0 as a source always yields tag 0. Index 0 as a destination allocates nothing, and that lane's destination and previous-mapping outputs read 0.
- R8: stall_o is high when the number of allocating lanes exceeds the free count. While stalled, no tag is consumed and the table is not written.
- R9: A tag presented on the free port joins the tail of the queue at the clock edge. It can first be allocated in the following cycle, in FIFO order.
- R10: A lane that does not allocate (invalid, or write flag low) drives 0 on its destination and previous-mapping outputs and consumes no tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vld_i | input | 2 | Lane valid, bit n for lane n |
| wen_i | input | 2 | Lane writes a destination |
| rd_i | input | 2x$clog2(ARCH_REGS) | Destination architectural index per lane |
| rs1_i | input | 2x$clog2(ARCH_REGS) | First source architectural index per lane |
| rs2_i | input | 2x$clog2(ARCH_REGS) | Second source architectural index per lane |
| free_vld_i | input | 1 | Release a physical register this cycle |
| free_tag_i | input | $clog2(PHYS_REGS) | Physical register being released |
| stall_o | output | 1 | Group held back for lack of free registers |
| ps1_o | output | 2x$clog2(PHYS_REGS) | First source physical tag per lane |
| ps2_o | output | 2x$clog2(PHYS_REGS) | Second source physical tag per lane |
| pd_o | output | 2x$clog2(PHYS_REGS) | New destination physical tag per lane |
| pold_o | output | 2x$clog2(PHYS_REGS) | Previous mapping of the destination per lane |

## Verification
A corrupted table entry shows up the next time any lane reads that architectural index as a source or destination, combinationally in that same cycle. A free queue with a bad pointer or count shows up as a duplicate or wrong destination tag, or as a stall asserted at the wrong moment, on the first allocation that reaches the damaged slot. A missed same-group substitution is visible in the same cycle as the lane 1 source or previous-mapping output. The random phase uses small index ranges so that lane collisions and queue wrap-around happen often.

// File: rtl/dual_rename_pkg.sv
package dual_rename_pkg;
  localparam int unsigned RN_LANES = 2;
  localparam int unsigned RN_OPS   = 3;  // rs1, rs2, rd per lane
  localparam int unsigned OP_RS1   = 0;
  localparam int unsigned OP_RS2   = 1;
  localparam int unsigned OP_RD    = 2;
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int unsigned ARCH_REGS = 32,
  parameter int unsigned PHYS_REGS = 64,
  parameter int unsigned NRD       = 6,
  localparam int unsigned AW = $clog2(ARCH_REGS),
  localparam int unsigned PW = $clog2(PHYS_REGS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NRD-1:0][AW-1:0]   raddr_i,
  output logic [NRD-1:0][PW-1:0]   rdata_o,
  input  logic [1:0]               we_i,
  input  logic [1:0][AW-1:0]       waddr_i,
  input  logic [1:0][PW-1:0]       wdata_i
);
  logic [PW-1:0] map_q [ARCH_REGS];

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata_o[r] = map_q[raddr_i[r]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ARCH_REGS; i++) map_q[i] <= PW'(i);
    end else begin
      // lane 1 written last so it wins a same-index collision
      for (int l = 0; l < 2; l++) begin
        if (we_i[l]) map_q[waddr_i[l]] <= wdata_i[l];
      end
    end
  end
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int unsigned ARCH_REGS = 32,
  parameter int unsigned PHYS_REGS = 64,
  localparam int unsigned PW = $clog2(PHYS_REGS),
  localparam int unsigned CW = PW + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          req_i,
  input  logic                take_i,
  output logic [1:0][PW-1:0]  tag_o,
  output logic [CW-1:0]       cnt_o,
  input  logic                push_i,
  input  logic [PW-1:0]       push_tag_i
);
  localparam int unsigned INIT_CNT = PHYS_REGS - ARCH_REGS;

  logic [PW-1:0] ring_q [PHYS_REGS];
  logic [PW-1:0] head_q, tail_q, head_p1, head_nx;
  logic [CW-1:0] cnt_q;
  logic [1:0]    npop;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(PHYS_REGS - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head_p1  = wrap_inc(head_q);
  assign tag_o[0] = ring_q[head_q];
  assign tag_o[1] = req_i[0] ? ring_q[head_p1] : ring_q[head_q];
  assign npop     = take_i ? (2'(req_i[0]) + 2'(req_i[1])) : 2'd0;
  assign cnt_o    = cnt_q;

  always_comb begin
    case (npop)
      2'd1:    head_nx = head_p1;
      2'd2:    head_nx = wrap_inc(head_p1);
      default: head_nx = head_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PHYS_REGS; i++)
        ring_q[i] <= (i < INIT_CNT) ? PW'(ARCH_REGS + i) : '0;
      head_q <= '0;
      tail_q <= PW'(INIT_CNT);
      cnt_q  <= CW'(INIT_CNT);
    end else begin
      head_q <= head_nx;
      if (push_i) begin
        ring_q[tail_q] <= push_tag_i;
        tail_q         <= wrap_inc(tail_q);
      end
      cnt_q <= cnt_q - CW'(npop) + CW'(push_i);
    end
  end
endmodule

// File: rtl/rn_dep_fix.sv
module rn_dep_fix
  import dual_rename_pkg::*;
#(
  parameter int unsigned AW = 5,
  parameter int unsigned PW = 6
) (
  input  logic                     alloc0_i,
  input  logic [AW-1:0]            rd0_i,
  input  logic [PW-1:0]            pd0_i,
  input  logic [RN_OPS-1:0][AW-1:0] addr_i,
  input  logic [RN_OPS-1:0][PW-1:0] tbl_i,
  output logic [RN_OPS-1:0][PW-1:0] fix_o
);
  // compares depend only on indices, so they run beside the table read
  for (genvar o = 0; o < RN_OPS; o++) begin : g_op
    logic hit;
    assign hit      = alloc0_i && (addr_i[o] == rd0_i);
    assign fix_o[o] = hit ? pd0_i : tbl_i[o];
  end
endmodule

// File: rtl/dual_rename.sv
module dual_rename
  import dual_rename_pkg::*;
#(
  parameter int unsigned ARCH_REGS = 32,
  parameter int unsigned PHYS_REGS = 64,
  localparam int unsigned AW = $clog2(ARCH_REGS),
  localparam int unsigned PW = $clog2(PHYS_REGS),
  localparam int unsigned CW = PW + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          vld_i,
  input  logic [1:0]          wen_i,
  input  logic [1:0][AW-1:0]  rd_i,
  input  logic [1:0][AW-1:0]  rs1_i,
  input  logic [1:0][AW-1:0]  rs2_i,
  input  logic                free_vld_i,
  input  logic [PW-1:0]       free_tag_i,
  output logic                stall_o,
  output logic [1:0][PW-1:0]  ps1_o,
  output logic [1:0][PW-1:0]  ps2_o,
  output logic [1:0][PW-1:0]  pd_o,
  output logic [1:0][PW-1:0]  pold_o
);
  localparam int unsigned NRD = RN_LANES * RN_OPS;

  logic [1:0]                alloc;
  logic [1:0]                need;
  logic [CW-1:0]             free_cnt;
  logic [1:0][PW-1:0]        fl_tag;
  logic [NRD-1:0][AW-1:0]    raddr;
  logic [NRD-1:0][PW-1:0]    rdata;
  logic [RN_OPS-1:0][AW-1:0] l1_addr;
  logic [RN_OPS-1:0][PW-1:0] l1_tbl, l1_fix;
  logic [1:0]                tbl_we;

  for (genvar l = 0; l < RN_LANES; l++) begin : g_lane
    assign alloc[l]                 = vld_i[l] && wen_i[l] && (rd_i[l] != '0);
    assign raddr[l*RN_OPS + OP_RS1] = rs1_i[l];
    assign raddr[l*RN_OPS + OP_RS2] = rs2_i[l];
    assign raddr[l*RN_OPS + OP_RD]  = rd_i[l];
    assign pd_o[l]                  = alloc[l] ? fl_tag[l] : '0;
    assign tbl_we[l]                = alloc[l] && !stall_o;
  end

  assign need    = 2'(alloc[0]) + 2'(alloc[1]);
  assign stall_o = CW'(need) > free_cnt;

  rn_map_table #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS), .NRD(NRD)) u_map (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raddr_i (raddr),
    .rdata_o (rdata),
    .we_i    (tbl_we),
    .waddr_i (rd_i),
    .wdata_i (pd_o)
  );

  rn_free_list #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_fl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (alloc),
    .take_i     (!stall_o),
    .tag_o      (fl_tag),
    .cnt_o      (free_cnt),
    .push_i     (free_vld_i),
    .push_tag_i (free_tag_i)
  );

  for (genvar o = 0; o < RN_OPS; o++) begin : g_l1
    assign l1_addr[o] = raddr[RN_OPS + o];
    assign l1_tbl[o]  = rdata[RN_OPS + o];
  end

  rn_dep_fix #(.AW(AW), .PW(PW)) u_fix (
    .alloc0_i (alloc[0]),
    .rd0_i    (rd_i[0]),
    .pd0_i    (pd_o[0]),
    .addr_i   (l1_addr),
    .tbl_i    (l1_tbl),
    .fix_o    (l1_fix)
  );

  assign ps1_o[0]  = rdata[OP_RS1];
  assign ps2_o[0]  = rdata[OP_RS2];
  assign pold_o[0] = alloc[0] ? rdata[OP_RD] : '0;
  assign ps1_o[1]  = l1_fix[OP_RS1];
  assign ps2_o[1]  = l1_fix[OP_RS2];
  assign pold_o[1] = alloc[1] ? l1_fix[OP_RD] : '0;
endmodule

// File: rtl/dual_rename_chk.sv
module dual_rename_chk #(
  parameter int unsigned AW = 5,
  parameter int unsigned PW = 6,
  parameter int unsigned CW = 7
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [1:0]         vld_i,
  input logic [1:0]         wen_i,
  input logic [1:0][AW-1:0] rd_i,
  input logic [1:0][AW-1:0] rs1_i,
  input logic               free_vld_i,
  input logic               stall_o,
  input logic [1:0][PW-1:0] ps1_o,
  input logic [1:0][PW-1:0] pd_o,
  input logic [CW-1:0]      cnt
);
  logic a0, a1;
  assign a0 = vld_i[0] && wen_i[0] && (rd_i[0] != '0);
  assign a1 = vld_i[1] && wen_i[1] && (rd_i[1] != '0);

  a_r2_distinct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a0 && a1 && !stall_o) |-> (pd_o[0] != pd_o[1]));
  a_r2_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a0 && !stall_o) |-> (pd_o[0] != '0));
  a_r7_x0_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i[0] && rs1_i[0] == '0) |-> (ps1_o[0] == '0));
  a_r8_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !free_vld_i) |=> (cnt == $past(cnt)));
  a_r9_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!a0 && !a1 && free_vld_i) |=> (cnt == $past(cnt) + 1'b1));
  a_r10_nodest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wen_i[1]) |-> (pd_o[1] == '0));
endmodule

bind dual_rename dual_rename_chk #(.AW(AW), .PW(PW), .CW(CW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .vld_i      (vld_i),
  .wen_i      (wen_i),
  .rd_i       (rd_i),
  .rs1_i      (rs1_i),
  .free_vld_i (free_vld_i),
  .stall_o    (stall_o),
  .ps1_o      (ps1_o),
  .pd_o       (pd_o),
  .cnt        (free_cnt)
);

// File: tb/dual_rename_test.sv
module dual_rename_test;
  localparam int ARCH = 32;
  localparam int PHYS = 64;
  localparam int AW = $clog2(ARCH);
  localparam int PW = $clog2(PHYS);

  logic clk = 0, rst_n = 0;
  logic [1:0] vld = 0, wen = 0;
  logic [1:0][AW-1:0] rd = '0, rs1 = '0, rs2 = '0;
  logic free_vld = 0;
  logic [PW-1:0] free_tag = '0;
  logic stall;
  logic [1:0][PW-1:0] ps1, ps2, pd, pold;

  always #2 clk = ~clk;

  dual_rename #(.ARCH_REGS(ARCH), .PHYS_REGS(PHYS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .vld_i(vld), .wen_i(wen), .rd_i(rd),
    .rs1_i(rs1), .rs2_i(rs2), .free_vld_i(free_vld), .free_tag_i(free_tag),
    .stall_o(stall), .ps1_o(ps1), .ps2_o(ps2), .pd_o(pd), .pold_o(pold));

  int checks = 0, fails = 0;
  int m_map [ARCH];
  int m_fl [PHYS];
  int m_head = 0, m_tail = 0, m_cnt = 0;
  int pend [512];
  int p_head = 0, p_tail = 0;
  int o_ps1 [2], o_ps2 [2], o_pd [2], o_pold [2], o_stall;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input int v0, w0, d0, a0, b0, v1, w1, d1, a1, b1, fv, ft);
    vld = 2'(v0) | (2'(v1) << 1);
    wen = 2'(w0) | (2'(w1) << 1);
    rd[0] = AW'(d0); rs1[0] = AW'(a0); rs2[0] = AW'(b0);
    rd[1] = AW'(d1); rs1[1] = AW'(a1); rs2[1] = AW'(b1);
    free_vld = fv[0]; free_tag = PW'(ft);
  endtask

  function automatic int lane_src(input int l, input int s, input int al0, input int epd0);
    if (l == 1 && al0 != 0 && s == int'(rd[0])) return epd0;
    return m_map[s];
  endfunction

  // inputs set just after negedge; compare mid-cycle, then advance model at posedge
  task automatic cycle();
    int al [2];
    int need, est;
    int epd [2], epold [2];
    #1;
    for (int l = 0; l < 2; l++) al[l] = (vld[l] && wen[l] && rd[l] != 0) ? 1 : 0;
    need = al[0] + al[1];
    est = (need > m_cnt) ? 1 : 0;
    epd[0] = al[0] ? m_fl[m_head] : 0;
    epd[1] = al[1] ? (al[0] ? m_fl[(m_head + 1) % PHYS] : m_fl[m_head]) : 0;
    epold[0] = al[0] ? m_map[rd[0]] : 0;
    epold[1] = al[1] ? lane_src(1, int'(rd[1]), al[0], epd[0]) : 0;
    for (int l = 0; l < 2; l++) begin
      o_ps1[l] = int'(ps1[l]); o_ps2[l] = int'(ps2[l]);
      o_pd[l] = int'(pd[l]); o_pold[l] = int'(pold[l]);
    end
    o_stall = int'(stall);
    chk("R8 stall", o_stall, est);
    if (!est) begin
      for (int l = 0; l < 2; l++) begin
        if (vld[l]) begin
          chk((l == 1 && al[0] && rs1[1] == rd[0]) ? "R4 ps1" : "R3 ps1",
              o_ps1[l], lane_src(l, int'(rs1[l]), al[0], epd[0]));
          chk((l == 1 && al[0] && rs2[1] == rd[0]) ? "R4 ps2" : "R3 ps2",
              o_ps2[l], lane_src(l, int'(rs2[l]), al[0], epd[0]));
        end
        chk(al[l] ? "R2 pd" : "R10 pd", o_pd[l], epd[l]);
        chk(al[l] ? "R5 pold" : "R10 pold", o_pold[l], epold[l]);
      end
    end
    @(posedge clk);
    if (!est) begin
      for (int l = 0; l < 2; l++) if (al[l]) begin
        m_map[rd[l]] = epd[l];
        pend[p_tail % 512] = epold[l]; p_tail++;
      end
      m_head = (m_head + need) % PHYS;
      m_cnt -= need;
    end
    if (free_vld) begin
      m_fl[m_tail] = int'(free_tag);
      m_tail = (m_tail + 1) % PHYS;
      m_cnt++;
    end
    @(negedge clk);
  endtask

  function automatic int rnd_reg();
    return ($urandom % 4 == 0) ? int'($urandom % ARCH) : int'($urandom % 6);
  endfunction

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int ft;
    void'($urandom(32'd20240611));
    for (int i = 0; i < ARCH; i++) m_map[i] = i;
    for (int i = 0; i < PHYS - ARCH; i++) m_fl[i] = ARCH + i;
    m_tail = PHYS - ARCH; m_cnt = PHYS - ARCH;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state, same-group RAW and WAW on x3
    drive(1, 1, 3, 5, 0, 1, 1, 3, 3, 31, 0, 0);
    cycle();
    chk("R1 src ident", o_ps1[0], 5);
    chk("R7 x0 src", o_ps2[0], 0);
    chk("R1 first tag", o_pd[0], ARCH);
    chk("R5 pold lane0", o_pold[0], 3);
    chk("R4 raw fwd", o_ps1[1], ARCH);
    chk("R3 plain src", o_ps2[1], 31);
    chk("R5 pold lane1", o_pold[1], ARCH);
    chk("R2 second tag", o_pd[1], ARCH + 1);

    // WAW winner, no-write lane, x0 destination
    drive(1, 0, 7, 3, 0, 1, 1, 0, 3, 0, 0, 0);
    cycle();
    chk("R6 waw winner", o_ps1[0], ARCH + 1);
    chk("R10 no write pd", o_pd[0], 0);
    chk("R7 x0 dest pd", o_pd[1], 0);
    chk("R7 x0 dest pold", o_pold[1], 0);

    // drain the free queue: 30 left, 15 double allocations
    for (int i = 0; i < 15; i++) begin
      drive(1, 1, 1 + (i % 30), 2, 4, 1, 1, 2 + (i % 29), 6, 8, 0, 0);
      cycle();
    end
    drive(1, 1, 9, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    cycle();
    chk("R8 empty stall", o_stall, 1);
    ft = pend[p_head % 512]; p_head++;
    chk("R9 free tag is 3", ft, 3);
    drive(1, 1, 9, 1, 1, 0, 0, 0, 0, 0, 1, ft);
    cycle();
    chk("R9 not yet usable", o_stall, 1);
    drive(1, 1, 9, 1, 1, 1, 1, 10, 1, 1, 0, 0);
    cycle();
    chk("R8 partial stall", o_stall, 1);
    drive(1, 1, 9, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    cycle();
    chk("R9 reused tag", o_pd[0], 3);
    chk("R8 nothing consumed", o_stall, 0);

    // random traffic with commit-side frees
    for (int n = 0; n < 4000; n++) begin
      int fv;
      fv = (p_tail > p_head && $urandom % 3 != 0) ? 1 : 0;
      ft = fv ? pend[p_head % 512] : 0;
      if (fv) p_head++;
      drive(int'($urandom % 4 != 0), int'($urandom % 4 != 0), rnd_reg(), rnd_reg(), rnd_reg(),
            int'($urandom % 4 != 0), int'($urandom % 4 != 0), rnd_reg(), rnd_reg(), rnd_reg(),
            fv, ft);
      cycle();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule